// File: doc/BRIEF.md
# Full-Period Permutation Table Generator

This block produces, at configuration time, the private port-ordering table that one mesh switch uses to decode obfuscated route steps. The five routing directions (north, south, east, west, local) can be ordered in 120 ways. Each request picks one of these orderings by rank. The rank comes from a linear congruential generator with modulus 120. Its multiplier and increment satisfy the full-period conditions, so every rank appears once before any repeats.

For a given rank, the block starts from the identity ordering and applies the lexicographic successor step once per clock until it reaches that rank. The successor step works as follows:
- Find the rightmost position whose entry is smaller than its right neighbour (the pivot).
- Swap the pivot with the rightmost later entry that is larger than it.
- Reverse everything to the right of the pivot.

When the ordering is complete, the block pulses `done` with the five 3-bit entries and the rank that was used. It can then be asked again for the next switch's table. A seed port starts the sequence at a chosen point.

The control is a three-state machine:
- **IDLE** accepts seeds and requests, and `req_ready` is high. The transition `accept` (request seen while idle) leads to STEP.
- **STEP** applies one successor step per cycle while the remaining count is nonzero (transition `advance`, staying in STEP). When the count is zero it takes transition `finish` to DONE.
- **DONE** holds `done` high for one cycle and then takes transition `release` back to IDLE.

Top module: `perm_table_gen`

## Requirements
- R1: After reset, `req_ready`=1, `done`=0, `index_out`=0, and `table_out` holds the identity ordering. Entry k sits at bits [3k+2:3k]. The direction codes are north=0, south=1, east=2, west=3, local=4, and identity is entry k = k.
- R2: A `seed_load` pulse while idle sets the generator state to `seed_value` mod 120. The next accepted request uses that value as its rank. A request in the same idle cycle already uses the new value.
- R3: After each accepted request, the generator state becomes (61·x + 7) mod 120, and the following request uses that value as its rank.
- R4: Over 120 consecutive requests without reseeding, every rank 0..119 is reported exactly once.
- R5: `table_out` at `done` is the ordering at lexicographic rank `index_out` among all orderings of {0..4}, with entry 0 the most significant position in the comparison.
- R6: Rank 0 gives the identity ordering (0,1,2,3,4), and rank 119 gives the fully reversed ordering (4,3,2,1,0).
- R7: `done` is high for exactly one cycle, rank+2 cycles after the clock edge that accepts the request.
- R8: `req_ready` is low from the cycle after acceptance through the `done` cycle. A request raised while `req_ready` is low is ignored and causes no later `done`.
- R9: A `seed_load` raised while busy is ignored: the rank sequence continues as per R3.
- R10: `table_out` and `index_out` hold their values while idle with no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| seed_load | input | 1 | Load `seed_value` into the generator (idle only) |
| seed_value | input | SEED_W (8) | Seed, reduced mod 120 on load |
| req_valid | input | 1 | Request a new table |
| req_ready | output | 1 | High while idle; a request is accepted when both are high |
| done | output | 1 | One-cycle pulse: table and rank are valid |
| index_out | output | 7 | Rank used for the latest table |
| table_out | output | 15 | Five 3-bit direction codes, entry k at [3k+2:3k] |

## Verification
A wrong generator state shows up at the first `done` after it goes wrong: the reported rank leaves the 61·x+7 sequence. Within at most 120 requests, it also shows up as a repeated rank. A fault in the successor step shows up at the first request whose rank needs that step, as a table that is not at the reported lexicographic rank, or not a permutation at all. A miscounting step counter or state machine shows up within one request, as a `done` that comes early, comes late, or is missing.

// File: rtl/ptg_pkg.sv
package ptg_pkg;
    localparam int NDIR  = 5;
    localparam int DIR_W = 3;
    localparam int NPERM = 120;
    localparam int IDX_W = $clog2(NPERM);

    typedef logic [DIR_W-1:0] dir_t;
    typedef dir_t [NDIR-1:0] perm_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_STEP,
        ST_DONE
    } ptg_state_t;

    function automatic perm_t identity_perm();
        perm_t p;
        for (int k = 0; k < NDIR; k++) p[k] = DIR_W'(k);
        return p;
    endfunction
endpackage

// File: rtl/perm_lcg.sv
module perm_lcg
    import ptg_pkg::*;
#(
    parameter int SEED_W = 8,
    parameter int LCG_A  = 61,
    parameter int LCG_C  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [SEED_W-1:0] seed,
    input  logic              advance,
    output logic [IDX_W-1:0]  cur_idx
);
    logic [IDX_W-1:0]  x_q;
    logic [SEED_W-1:0] seed_red;
    logic [31:0]       mul;
    logic [IDX_W-1:0]  x_next;

    always_comb begin
        seed_red = seed % SEED_W'(NPERM);
        cur_idx  = load ? IDX_W'(seed_red) : x_q;
        mul      = 32'(LCG_A) * 32'(cur_idx) + 32'(LCG_C);
        x_next   = IDX_W'(mul % 32'(NPERM));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       x_q <= '0;
        else if (advance) x_q <= x_next;
        else if (load)    x_q <= cur_idx;
    end

    // R3: generator state never leaves the modulus range
    a_r3_state_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        x_q < IDX_W'(NPERM));
endmodule

// File: rtl/perm_succ.sv
module perm_succ
    import ptg_pkg::*;
(
    input  perm_t cur,
    output perm_t nxt
);
    perm_t sw;
    int    piv;
    int    big;

    always_comb begin
        piv = -1;
        for (int i = 0; i < NDIR-1; i++)
            if (cur[i] < cur[i+1]) piv = i;
        sw  = cur;
        big = 0;
        nxt = cur;
        if (piv < 0) begin
            for (int k = 0; k < NDIR; k++) nxt[k] = cur[NDIR-1-k];
        end else begin
            for (int k = 0; k < NDIR; k++)
                if (k > piv && cur[k] > cur[3'(piv)]) big = k;
            sw[3'(piv)] = cur[3'(big)];
            sw[3'(big)] = cur[3'(piv)];
            nxt = sw;
            for (int k = 0; k < NDIR; k++)
                if (k > piv) nxt[k] = sw[3'(piv + NDIR - k)];
        end
    end
endmodule

// File: rtl/perm_table_gen.sv
module perm_table_gen
    import ptg_pkg::*;
#(
    parameter int SEED_W = 8,
    parameter int LCG_A  = 61,
    parameter int LCG_C  = 7
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   seed_load,
    input  logic [SEED_W-1:0]      seed_value,
    input  logic                   req_valid,
    output logic                   req_ready,
    output logic                   done,
    output logic [IDX_W-1:0]       index_out,
    output logic [NDIR*DIR_W-1:0]  table_out
);
    ptg_state_t       state_q, state_d;
    logic [IDX_W-1:0] cnt_q, idx_q, cur_idx;
    perm_t            tbl_q, tbl_succ;
    logic             accept;
    logic [NDIR-1:0]  seen_mask;

    assign accept = req_valid && (state_q == ST_IDLE);

    perm_lcg #(.SEED_W(SEED_W), .LCG_A(LCG_A), .LCG_C(LCG_C)) u_lcg (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (seed_load && (state_q == ST_IDLE)),
        .seed    (seed_value),
        .advance (accept),
        .cur_idx (cur_idx)
    );

    perm_succ u_succ (
        .cur (tbl_q),
        .nxt (tbl_succ)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept) state_d = ST_STEP;
            ST_STEP: if (cnt_q == '0) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            idx_q <= '0;
            tbl_q <= identity_perm();
        end else if (accept) begin
            cnt_q <= cur_idx;
            idx_q <= cur_idx;
            tbl_q <= identity_perm();
        end else if (state_q == ST_STEP && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
            tbl_q <= tbl_succ;
        end
    end

    // outputs
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        done      = (state_q == ST_DONE);
        index_out = idx_q;
        table_out = tbl_q;
    end

    always_comb begin
        seen_mask = '0;
        for (int k = 0; k < NDIR; k++)
            if (tbl_q[k] < DIR_W'(NDIR)) seen_mask[tbl_q[k]] = 1'b1;
    end

    // R8: once accepted, the block is busy on the next cycle
    a_r8_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
    // R7: done lasts a single cycle
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R5: completed table is a permutation of the five codes
    a_r5_is_permutation: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (seen_mask == {NDIR{1'b1}}));
    // R10: outputs hold while idle without request
    a_r10_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && !req_valid) |=> ($stable(table_out) && $stable(index_out)));
    // R6: rank 0 produces the identity ordering
    a_r6_rank0_identity: assert property (@(posedge clk) disable iff (!rst_n)
        (done && index_out == '0) |-> (table_out == identity_perm()));
    // R3: reported rank stays within range
    a_r3_rank_range: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (index_out < IDX_W'(NPERM)));
endmodule

// File: tb/perm_table_gen_test.sv
module perm_table_gen_test;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        seed_load = 0;
    logic [7:0]  seed_value = 0;
    logic        req_valid = 0;
    logic        req_ready, done;
    logic [6:0]  index_out;
    logic [14:0] table_out;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    int model_x = 0;

    perm_table_gen uut (
        .clk(clk), .rst_n(rst_n), .seed_load(seed_load), .seed_value(seed_value),
        .req_valid(req_valid), .req_ready(req_ready), .done(done),
        .index_out(index_out), .table_out(table_out)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            bad++; total++;
            $display("FAIL watchdog: actual=%0d cycles expected<=150000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic int fact(int n);
        int f = 1;
        for (int i = 2; i <= n; i++) f *= i;
        return f;
    endfunction

    // lexicographic rank -> table, by factorial digits
    function automatic logic [14:0] rank_table(int r);
        int avail[5];
        int cnt = 5;
        logic [14:0] t = '0;
        for (int i = 0; i < 5; i++) avail[i] = i;
        for (int pos = 0; pos < 5; pos++) begin
            int f = fact(4 - pos);
            int d = r / f;
            r = r % f;
            t[pos*3 +: 3] = 3'(avail[d]);
            for (int j = d; j < cnt - 1; j++) avail[j] = avail[j+1];
            cnt--;
        end
        return t;
    endfunction

    function automatic int lcg_next(int x);
        return (61 * x + 7) % 120;
    endfunction

    task automatic check(string req, int got, int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, got, exp);
        end
    endtask

    task automatic load_seed(int s);
        @(negedge clk);
        seed_load = 1; seed_value = 8'(s);
        @(negedge clk);
        seed_load = 0;
        model_x = s % 120;
    endtask

    // mode 0: plain, 1: request pulse while busy, 2: seed pulse while busy
    task automatic do_request(int mode, output int idx, output logic [14:0] tbl);
        int lat;
        int exp_idx = model_x;
        @(negedge clk);
        req_valid = 1;
        @(negedge clk);
        req_valid = 0;
        lat = 1;
        check("R8 busy", int'(req_ready), 0);
        if (mode == 1) req_valid = 1;
        if (mode == 2) begin seed_load = 1; seed_value = 8'd55; end
        while (!done && lat < 300) begin
            @(negedge clk);
            req_valid = 0; seed_load = 0;
            lat++;
        end
        idx = int'(index_out);
        tbl = table_out;
        check("R3 rank", idx, exp_idx);
        check("R5 table", int'(tbl), int'(rank_table(exp_idx)));
        check("R7 latency", lat, exp_idx + 2);
        model_x = lcg_next(model_x);
        @(negedge clk);
        check("R7 single pulse", int'(done), 0);
        check("R8 ready back", int'(req_ready), 1);
    endtask

    initial begin
        int idx;
        logic [14:0] tbl;
        bit seen[120];
        void'($urandom(32'd4242));

        repeat (3) @(negedge clk);
        check("R1 ready", int'(req_ready), 1);
        check("R1 done", int'(done), 0);
        check("R1 index", int'(index_out), 0);
        check("R1 table", int'(table_out), 18056);
        rst_n = 1;

        // R2 and R6: rank 0 identity
        load_seed(0);
        do_request(0, idx, tbl);
        check("R2 seed 0", idx, 0);
        check("R6 identity", int'(tbl), 18056);

        // R6: rank 119 reversed
        load_seed(119);
        do_request(0, idx, tbl);
        check("R6 reversed", int'(tbl), 668);

        // R2: reduction mod 120
        load_seed(200);
        do_request(0, idx, tbl);
        check("R2 seed 200", idx, 80);
        // R3: next rank continues the recurrence
        do_request(0, idx, tbl);
        check("R3 after 80", idx, 87);

        // R2: seed and request in the same idle cycle
        @(negedge clk);
        seed_load = 1; seed_value = 8'd250;
        model_x = 250 % 120;
        do_request(0, idx, tbl);
        check("R2 same-cycle seed", idx, 10);

        // R8: request while busy ignored
        do_request(1, idx, tbl);
        repeat (5) begin
            @(negedge clk);
            check("R8 no extra done", int'(done), 0);
        end
        // R10: outputs held while idle
        check("R10 hold table", int'(table_out), int'(rank_table(idx)));
        check("R10 hold index", int'(index_out), idx);

        // R9: seed while busy ignored (model continues)
        do_request(2, idx, tbl);
        do_request(0, idx, tbl);

        // R4: full period from a random seed
        load_seed(int'($urandom_range(0, 255)));
        for (int i = 0; i < 120; i++) seen[i] = 0;
        for (int n = 0; n < 120; n++) begin
            do_request(0, idx, tbl);
            check("R4 unique rank", int'(seen[idx]), 0);
            seen[idx] = 1;
        end

        // random seeds, mixed
        for (int n = 0; n < 10; n++) begin
            load_seed(int'($urandom_range(0, 255)));
            do_request(0, idx, tbl);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule